// File: doc/BRIEF.md
# Video Output Sync and Mode-Pin Control Path

This block is the digital control path in front of a three-channel video output stage. It watches a synchronous sync input. A fixed number of clocks after each sync transition it takes one sample of a shared configuration pin. The direction of the latest transition decides which of two stored flags that sample updates. A falling edge updates the sync-span flag, which chooses between insertion on one channel and insertion on all channels. A rising edge updates the mode flag. A second configuration pin is static and is registered every cycle.

Each output channel is a registered code that takes one of four sources. It can pass its data input through, hold the blanking code, or carry the sync level. While sync is low, the sync level goes on channel 0 alone or on every channel, as the span flag selects, and a polarity input selects its value. A system that needs the two shared-pin flags at different levels can drive the shared pin from the sync signal delayed by two clocks, either straight or inverted.

Top module: `vid_sync_ctl`

## Requirements
- R1: While `rst` is high at a clock edge, all channel outputs are set to the blanking code (0), `span_all_o` and both bits of `mode_sel_o` are set to 0, and the stored last edge counts as rising.
- R2: A sync transition seen at clock edge E sets up a single sample of `shared_cfg_i`, taken at edge E+SAMPLE_DLY-1. This is the second edge after the transition with the default SAMPLE_DLY of 2. Neither flag changes at any other edge.
- R3: When the latest transition was high to low, the sample is written to `span_all_o` and `mode_sel_o[1]` keeps its value.
- R4: When the latest transition was low to high, the sample is written to `mode_sel_o[1]` and `span_all_o` keeps its value.
- R5: A new sync transition before the pending sample is taken restarts the delay and takes the new direction. The earlier sample is dropped and never written.
- R6: `mode_sel_o[0]` is `static_cfg_i` registered at each edge, with one cycle of latency and no dependence on sync.
- R7: When `sync_i` is low and `span_all_o` is 0, channel 0 (bits 9:0) shows the sync code after one clock, and channels 1 and 2 show the blanking code.
- R8: When `sync_i` is low and `span_all_o` is 1, all three channels show the sync code after one clock.
- R9: The sync code is 1023 when `sync_pol_i` is 1 and 0 when it is 0.
- R10: When `sync_i` is high and `blank_n_i` is 0, all channels show the blanking code 0 after one clock.
- R11: When `sync_i` and `blank_n_i` are both high, channel c shows `pix_i[10c+9:10c]` after one clock.
- R12: Driving `shared_cfg_i` with `sync_i` delayed by two clocks leaves `mode_sel_o[1]`=0 and `span_all_o`=1. Driving it with the inverted delayed sync leaves `mode_sel_o[1]`=1 and `span_all_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sync_i | input | 1 | Sync, active low; its edges schedule the shared-pin sample |
| sync_pol_i | input | 1 | Polarity of the inserted sync code (1 = 1023, 0 = 0) |
| blank_n_i | input | 1 | 0 forces the blanking code outside sync |
| static_cfg_i | input | 1 | Static configuration pin, registered continuously |
| shared_cfg_i | input | 1 | Shared configuration pin, sampled after sync edges |
| pix_i | input | 30 | Three 10-bit input codes, channel 0 in the low bits |
| pix_o | output | 30 | Three registered 10-bit output codes |
| span_all_o | output | 1 | Sync-span flag: 1 = all channels, 0 = channel 0 only |
| mode_sel_o | output | 2 | Bit 1 = stored mode flag, bit 0 = registered static pin |

## Verification
The bench builds the block with its defaults: 10-bit codes, three channels and a two-clock sample delay. With these values the programming example with the delayed sync applies exactly, and the sync code of 1023 can be told apart from the blanking code. Because the delay is only two clocks, a second sync edge one cycle after the first falls inside the pending window, so the restart and the dropped sample can be observed. The scoreboard model is written for any delay, but only the default delay is run.

// File: rtl/vid_ctl_pkg.sv
package vid_ctl_pkg;
  typedef enum logic [1:0] {
    DRV_PASS     = 2'd0,
    DRV_BLANK    = 2'd1,
    DRV_SYNC_ONE = 2'd2,
    DRV_SYNC_ALL = 2'd3
  } drv_sel_e;
endpackage

// File: rtl/vid_cfg_sampler.sv
module vid_cfg_sampler #(
  parameter int SAMPLE_DLY = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sync_i,
  input  logic shared_cfg_i,
  output logic span_all_o,
  output logic mode_hi_o
);
  localparam int CW = $clog2(SAMPLE_DLY + 1);
  localparam logic [CW-1:0] LOAD = CW'(SAMPLE_DLY - 1);

  logic          sync_d;
  logic          last_rise;
  logic [CW-1:0] cnt;
  logic          edge_seen;

  assign edge_seen = (sync_i != sync_d);

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_d     <= 1'b1;
      last_rise  <= 1'b1;
      cnt        <= '0;
      span_all_o <= 1'b0;
      mode_hi_o  <= 1'b0;
    end else begin
      sync_d <= sync_i;
      if (edge_seen) begin
        cnt       <= LOAD;
        last_rise <= sync_i;
      end else if (cnt != '0) begin
        cnt <= cnt - 1'b1;
        if (cnt == CW'(1)) begin
          if (last_rise) mode_hi_o  <= shared_cfg_i;
          else           span_all_o <= shared_cfg_i;
        end
      end
    end
  end

  // R2
  flag_no_edge_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && (span_all_o != $past(span_all_o) || mode_hi_o != $past(mode_hi_o)))
      |-> ($past(sync_i) == $past(sync_d)));
  // R3
  span_on_fall_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && span_all_o != $past(span_all_o)) |-> !$past(last_rise));
  // R4
  mode_on_rise_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && mode_hi_o != $past(mode_hi_o)) |-> $past(last_rise));
endmodule

// File: rtl/vid_drv_decode.sv
module vid_drv_decode
  import vid_ctl_pkg::*;
(
  input  logic     sync_i,
  input  logic     blank_n_i,
  input  logic     span_all_i,
  output drv_sel_e sel_o
);
  always_comb begin
    if (!sync_i)        sel_o = span_all_i ? DRV_SYNC_ALL : DRV_SYNC_ONE;
    else if (blank_n_i) sel_o = DRV_PASS;
    else                sel_o = DRV_BLANK;
  end
endmodule

// File: rtl/vid_chan_out.sv
module vid_chan_out
  import vid_ctl_pkg::*;
#(
  parameter int DW = 10,
  parameter int NCH = 3,
  parameter logic [DW-1:0] BLANK_CODE = '0
) (
  input  logic            clk,
  input  logic            rst,
  input  drv_sel_e        sel_i,
  input  logic            sync_pol_i,
  input  logic [NCH*DW-1:0] pix_i,
  output logic [NCH*DW-1:0] pix_o
);
  logic [DW-1:0] sync_code;
  assign sync_code = sync_pol_i ? {DW{1'b1}} : {DW{1'b0}};

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [DW-1:0] nxt;
    always_comb begin
      case (sel_i)
        DRV_PASS:     nxt = pix_i[c*DW +: DW];
        DRV_SYNC_ALL: nxt = sync_code;
        DRV_SYNC_ONE: nxt = (c == 0) ? sync_code : BLANK_CODE;
        default:      nxt = BLANK_CODE;
      endcase
    end
    always_ff @(posedge clk) begin
      if (rst) pix_o[c*DW +: DW] <= BLANK_CODE;
      else     pix_o[c*DW +: DW] <= nxt;
    end
  end

  // R8
  sync_all_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(sel_i) == DRV_SYNC_ALL) |-> (pix_o == {NCH{$past(sync_code)}}));
  // R7
  sync_one_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(sel_i) == DRV_SYNC_ONE) |-> (pix_o[DW-1:0] == $past(sync_code)));
  // R10
  blank_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(sel_i) == DRV_BLANK) |-> (pix_o == {NCH{BLANK_CODE}}));
  // R11
  pass_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(sel_i) == DRV_PASS) |-> (pix_o == $past(pix_i)));
endmodule

// File: rtl/vid_sync_ctl.sv
module vid_sync_ctl
  import vid_ctl_pkg::*;
#(
  parameter int DW = 10,
  parameter int NCH = 3,
  parameter int SAMPLE_DLY = 2,
  parameter logic [DW-1:0] BLANK_CODE = '0
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                sync_i,
  input  logic                sync_pol_i,
  input  logic                blank_n_i,
  input  logic                static_cfg_i,
  input  logic                shared_cfg_i,
  input  logic [NCH*DW-1:0]   pix_i,
  output logic [NCH*DW-1:0]   pix_o,
  output logic                span_all_o,
  output logic [1:0]          mode_sel_o
);
  logic     span_all;
  logic     mode_hi;
  logic     static_q;
  drv_sel_e sel;

  vid_cfg_sampler #(.SAMPLE_DLY(SAMPLE_DLY)) u_sampler (
    .clk          (clk),
    .rst          (rst),
    .sync_i       (sync_i),
    .shared_cfg_i (shared_cfg_i),
    .span_all_o   (span_all),
    .mode_hi_o    (mode_hi)
  );

  vid_drv_decode u_decode (
    .sync_i     (sync_i),
    .blank_n_i  (blank_n_i),
    .span_all_i (span_all),
    .sel_o      (sel)
  );

  vid_chan_out #(.DW(DW), .NCH(NCH), .BLANK_CODE(BLANK_CODE)) u_chan (
    .clk        (clk),
    .rst        (rst),
    .sel_i      (sel),
    .sync_pol_i (sync_pol_i),
    .pix_i      (pix_i),
    .pix_o      (pix_o)
  );

  always_ff @(posedge clk) begin
    if (rst) static_q <= 1'b0;
    else     static_q <= static_cfg_i;
  end

  assign span_all_o = span_all;
  assign mode_sel_o = {mode_hi, static_q};

  // R6
  static_follow_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (mode_sel_o[0] == $past(static_cfg_i)));
endmodule

// File: tb/vid_sync_ctl_bench.sv
module vid_sync_ctl_bench;
  localparam int DW = 10;
  localparam int NCH = 3;
  localparam int DLY = 2;
  localparam int PW = NCH * DW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sync_i = 1'b1, sync_pol_i = 1'b1, blank_n_i = 1'b1;
  logic static_cfg_i = 1'b0, shared_cfg_i = 1'b0;
  logic [PW-1:0] pix_i = '0;
  logic [PW-1:0] pix_o;
  logic span_all_o;
  logic [1:0] mode_sel_o;

  int errors = 0;
  int checks = 0;

  always #2.5 clk = ~clk;

  vid_sync_ctl #(.DW(DW), .NCH(NCH), .SAMPLE_DLY(DLY)) u_vid_sync_ctl (
    .clk(clk), .rst(rst), .sync_i(sync_i), .sync_pol_i(sync_pol_i),
    .blank_n_i(blank_n_i), .static_cfg_i(static_cfg_i),
    .shared_cfg_i(shared_cfg_i), .pix_i(pix_i), .pix_o(pix_o),
    .span_all_o(span_all_o), .mode_sel_o(mode_sel_o)
  );

  typedef struct {
    logic [PW-1:0] pix;
    logic          span;
    logic          mode_hi;
    logic          m0;
    string         tag;
  } exp_t;
  exp_t q[$];

  // reference state built from the requirements
  logic m_sync_d = 1'b1, m_last_rise = 1'b1, m_span = 1'b0, m_mode = 1'b0;
  int   m_cnt = 0;

  always @(posedge clk) begin
    exp_t e;
    logic [DW-1:0] sc;
    if (rst) begin
      m_sync_d = 1'b1; m_last_rise = 1'b1; m_cnt = 0;
      m_span = 1'b0; m_mode = 1'b0;
      e.pix = '0; e.span = 1'b0; e.mode_hi = 1'b0; e.m0 = 1'b0; e.tag = "R1";
    end else begin
      sc = sync_pol_i ? 10'd1023 : 10'd0;
      if (!sync_i) begin
        if (m_span) begin e.pix = {sc, sc, sc}; e.tag = "R8 R9"; end
        else        begin e.pix = {10'd0, 10'd0, sc}; e.tag = "R7 R9"; end
      end else if (!blank_n_i) begin
        e.pix = '0; e.tag = "R10";
      end else begin
        e.pix = pix_i; e.tag = "R11";
      end
      if (sync_i != m_sync_d) begin
        m_cnt = DLY - 1; m_last_rise = sync_i;
      end else if (m_cnt != 0) begin
        if (m_cnt == 1) begin
          if (m_last_rise) m_mode = shared_cfg_i;
          else             m_span = shared_cfg_i;
        end
        m_cnt = m_cnt - 1;
      end
      m_sync_d = sync_i;
      e.span = m_span; e.mode_hi = m_mode; e.m0 = static_cfg_i;
    end
    q.push_back(e);
  end

  // monitor
  always @(negedge clk) begin
    exp_t e;
    if (q.size() > 0) begin
      e = q.pop_front();
      checks++;
      if (pix_o !== e.pix) begin
        errors++;
        $display("FAIL %s channels: actual=%h expected=%h", e.tag, pix_o, e.pix);
      end
      checks++;
      if (span_all_o !== e.span || mode_sel_o[1] !== e.mode_hi) begin
        errors++;
        $display("FAIL R2 R3 R4 flags: actual span=%b mode=%b expected span=%b mode=%b",
                 span_all_o, mode_sel_o[1], e.span, e.mode_hi);
      end
      checks++;
      if (mode_sel_o[0] !== e.m0) begin
        errors++;
        $display("FAIL R6 static: actual=%b expected=%b", mode_sel_o[0], e.m0);
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check_flags(input string tag, input logic exp_span, input logic exp_mode);
    checks++;
    if (span_all_o !== exp_span || mode_sel_o[1] !== exp_mode) begin
      errors++;
      $display("FAIL %s: actual span=%b mode=%b expected span=%b mode=%b",
               tag, span_all_o, mode_sel_o[1], exp_span, exp_mode);
    end
  endtask

  task automatic pixels(input int n);
    for (int i = 0; i < n; i++) begin
      pix_i = {10'(i * 37 + 5), 10'(i * 91 + 300), 10'(1023 - i * 13)};
      static_cfg_i = i[1];
      tick(1);
    end
  endtask

  task automatic delayed_run(input logic invert);
    logic d1, d2;
    d1 = sync_i; d2 = sync_i;
    for (int i = 0; i < 40; i++) begin
      if (i % 6 == 0) sync_i = ~sync_i;
      shared_cfg_i = invert ? ~d2 : d2;
      d2 = d1; d1 = sync_i;
      pix_i = {10'(i), 10'(i + 100), 10'(i + 200)};
      tick(1);
    end
    shared_cfg_i = invert ? ~d2 : d2;
    tick(4);
  endtask

  initial begin
    tick(3);
    // R1: reset state
    checks++;
    if (pix_o !== '0 || span_all_o !== 1'b0 || mode_sel_o !== 2'b00) begin
      errors++;
      $display("FAIL R1 reset: actual pix=%h span=%b mode=%b expected 0 0 0",
               pix_o, span_all_o, mode_sel_o);
    end
    rst = 1'b0;
    tick(1);
    // R11 pass-through, R6 static pin
    pixels(12);
    // R10 blanking
    blank_n_i = 1'b0; pixels(5); blank_n_i = 1'b1;
    // R2/R3: falling edge, sample 1 as span flag
    shared_cfg_i = 1'b1; sync_i = 1'b0;
    tick(1); check_flags("R2 before sample", 1'b0, 1'b0);
    tick(1); check_flags("R3 span after fall", 1'b1, 1'b0);
    shared_cfg_i = 1'b0;
    // R8 / R9 both polarities
    pixels(3); sync_pol_i = 1'b0; pixels(3); sync_pol_i = 1'b1;
    // R4: rising edge, sample 1 as mode flag
    shared_cfg_i = 1'b1; sync_i = 1'b1;
    tick(2); check_flags("R4 mode after rise", 1'b1, 1'b1);
    pixels(3);
    // R3 + R7: fall with 0 then single-channel sync
    shared_cfg_i = 1'b0; sync_i = 1'b0;
    tick(2); check_flags("R3 span cleared", 1'b0, 1'b1);
    pixels(4);
    // R4: rise with 0 clears mode
    sync_i = 1'b1; tick(2); check_flags("R4 mode cleared", 1'b0, 1'b0);
    // R5: fall then rise one cycle later, sample 1
    shared_cfg_i = 1'b1; sync_i = 1'b0; tick(1);
    sync_i = 1'b1; tick(1); check_flags("R5 first sample dropped", 1'b0, 1'b0);
    tick(1); check_flags("R5 restarted sample", 1'b0, 1'b1);
    tick(2); check_flags("R5 fall sample never written", 1'b0, 1'b1);
    // R12: delayed sync, then inverted delayed sync
    delayed_run(1'b0); check_flags("R12 delayed", 1'b1, 1'b0);
    delayed_run(1'b1); check_flags("R12 inverted", 1'b0, 1'b1);
    pixels(6);
    tick(2);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #100000;
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule